// File: doc/BRIEF.md
# Four-Mode Timer/Counter with Prescaler

This block is a 16-bit timer/counter built from two 8-bit halves. A 2-bit mode field decides how the halves are fed and joined. They can run as two separate timers, as a timer plus an event counter, as one cascaded 16-bit timer, or as one 16-bit event counter. Timer clocks come from a cycle-rate enable. That enable first passes through a fixed divide-by-four stage and then through an 8-bit reloadable down-counter. Event clocks come from an external input. That input is synchronised and then counted only on its rising edges.

Each half has its own match register. A half returns to zero on the step where it equals its match value, and raises a sticky flag at that point. The two flags feed two separate interrupt sources elsewhere on the chip. Software configures the block through a byte-wide write port. Software can read the whole 16-bit count at any time.

Top module: `split_timer16`

## Requirements
- R1: After a synchronous active-low reset, `count` is 0, both flags are 0, the mode is 0 (paired timers), both run bits are 0, both match registers are all ones and the reload register is 0.
- R2: The timer tick fires once every 4*(reload+1) cycles in which `cyc_en` is high. Cycles with `cyc_en` low do not advance the prescaler.
- R3: A write to the reload register (address 1) restarts the prescaler. The first tick then comes after 4*(new reload+1) enabled cycles, counted from the write.
- R4: In mode 0 each half counts prescaler ticks under its own run bit. On the tick where a half equals its match register, it goes to 0 and sets its own flag (low half sets `flag_lo`, high half sets `flag_hi`).
- R5: In mode 1 the low half counts prescaler ticks. The high half counts rising edges of `evt_in`.
- R6: In mode 2 both halves form one 16-bit timer on prescaler ticks. The high half advances when the low half wraps from 0xFF to 0.
- R7: In mode 3 the 16-bit value advances only on rising edges of `evt_in`.
- R8: In modes 2 and 3 the 16-bit value clears only when both halves equal their match registers. That event sets `flag_hi`, and `flag_lo` never sets in these modes.
- R9: `evt_in` passes through a two-flop synchroniser. A high level held for many cycles counts as one event, and each separate rising edge counts once. An event shows in `count` at the third clock edge after `evt_in` rises.
- R10: Writing address 4 with bit 0 (or bit 1) set clears `flag_lo` (or `flag_hi`). If a set condition occurs in the same cycle as the clear, the flag stays set.
- R11: A half with its run bit at 0 holds its value. In modes 2 and 3 the low run bit alone starts and stops the whole 16-bit counter.
- R12: Register port, written when `wr_en` is high:
  - address 0 is control: bits 1:0 hold the mode, bit 2 is the low run bit and bit 3 is the high run bit.
  - address 1 is the reload value.
  - address 2 is the low match register.
  - address 3 is the high match register.
  - address 4 is the flag clear register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cyc_en | input | 1 | Cycle-rate enable feeding the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| evt_in | input | 1 | External event input, asynchronous |
| flag_lo | output | 1 | Sticky low-half match flag |
| flag_hi | output | 1 | Sticky high-half (or 16-bit) match flag |
| count | output | 16 | Current count, high half in bits 15:8 |

## Verification
The assertions assume the following about the inputs:
- `evt_in` may change at any time, but every level it takes lasts over at least one rising clock edge.
- `wr_addr` values above 4 are never written.
- The flags change only through match events or address 4 writes.

The stimulus keeps within these limits. It changes inputs only on falling edges. It holds each event level for one or more whole cycles. It writes only the five defined addresses. Before each scenario it resets the block. It sets the run bits last, two edges after the reload write, so the tick positions are known exactly.

// File: rtl/split_timer16_pkg.sv
// Shared types and register addresses for the split 16-bit timer/counter.
// Assumes a byte-wide write port with a 3-bit address.
package split_timer16_pkg;

    // How the two halves are fed and joined
    typedef enum logic [1:0] {
        MODE_PAIR     = 2'd0,  // two prescaled 8-bit timers
        MODE_MIXED    = 2'd1,  // prescaled low timer, high event counter
        MODE_CASCADE  = 2'd2,  // one prescaled 16-bit timer
        MODE_EVENT16  = 2'd3   // one 16-bit event counter
    } tmr_mode_e;

    localparam int unsigned REG_ADDR_W = 3;

    localparam logic [REG_ADDR_W-1:0] REG_CTRL     = 3'd0;
    localparam logic [REG_ADDR_W-1:0] REG_RELOAD   = 3'd1;
    localparam logic [REG_ADDR_W-1:0] REG_MATCH_LO = 3'd2;
    localparam logic [REG_ADDR_W-1:0] REG_MATCH_HI = 3'd3;
    localparam logic [REG_ADDR_W-1:0] REG_FLAG_CLR = 3'd4;

endpackage

// File: rtl/stm_prescaler.sv
// Two-stage prescaler: a fixed FIX_W-bit divider followed by a PRE_W-bit
// reloadable down-counter. Emits a one-cycle tick when both stages reach
// terminal count on an enabled cycle. A load restarts both stages.
// Assumes cyc_en is synchronous to clk.
module stm_prescaler #(
    parameter int unsigned FIX_W = 2,
    parameter int unsigned PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_en,
    input  logic             load,
    input  logic [PRE_W-1:0] load_val,
    output logic             tick
);

    logic [FIX_W-1:0] fix_q;
    logic [PRE_W-1:0] down_q;
    logic [PRE_W-1:0] reload_q;
    logic             fix_done;

    // Fixed stage finishes once per 2**FIX_W enabled cycles
    assign fix_done = cyc_en && (&fix_q);
    // Tick when the programmable stage is at zero as the fixed stage finishes
    assign tick     = fix_done && (down_q == '0);

    // Store the reload value written by software
    always_ff @(posedge clk) begin
        if (!rst_n)    reload_q <= '0;
        else if (load) reload_q <= load_val;
    end

    // Advance both stages; a load restarts them from the new value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fix_q  <= '0;
            down_q <= '0;
        end else if (load) begin
            fix_q  <= '0;
            down_q <= load_val;
        end else if (cyc_en) begin
            fix_q <= fix_q + 1'b1;
            if (fix_done)
                down_q <= (down_q == '0) ? reload_q : down_q - 1'b1;
        end
    end

    AST_TICK_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load) |=> (down_q == reload_q)); // R2
    AST_LOAD_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (fix_q == '0 && down_q == $past(load_val))); // R3
    AST_IDLE_PAUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_en && !load) |=> ($stable(fix_q) && $stable(down_q))); // R2

endmodule

// File: rtl/stm_event_sync.sv
// Brings the asynchronous event input into the clock domain through
// SYNC_STAGES flops and reports a one-cycle pulse on each rising edge.
// Assumes every level of evt lasts across at least one clock edge.
module stm_event_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    output logic rise
);

    logic [SYNC_STAGES:0] shift_q;

    // Shift the input through the synchroniser plus one edge-detect flop
    always_ff @(posedge clk) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= {shift_q[SYNC_STAGES-1:0], evt};
    end

    assign rise = shift_q[SYNC_STAGES-1] && !shift_q[SYNC_STAGES];

    AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R9

endmodule

// File: rtl/stm_half.sv
// One W-bit half of the timer: clears on clr, else increments on step,
// and reports whether its value equals the supplied match value.
// Assumes clr is only raised together with step by the steering logic.
module stm_half #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         clr,
    input  logic [W-1:0] match_val,
    output logic [W-1:0] cnt,
    output logic         at_match
);

    logic [W-1:0] cnt_q;

    // Count register: clear takes priority over increment
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (clr)  cnt_q <= '0;
        else if (step) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt      = cnt_q;
    assign at_match = (cnt_q == match_val);

    AST_CLEAR_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0)); // R4
    AST_STEP_ADDS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R6
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr) |=> $stable(cnt_q)); // R11

endmodule

// File: rtl/split_timer16.sv
// Four-mode 16-bit timer/counter. Holds the software registers, steers
// prescaler ticks or synchronised event edges into two halves according
// to the mode, and keeps one sticky match flag per half.
// Assumes wr_addr values above 4 are never written.
module split_timer16
    import split_timer16_pkg::*;
#(
    parameter int unsigned HALF_W      = 8,
    parameter int unsigned PRE_W       = 8,
    parameter int unsigned FIX_W       = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cyc_en,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [HALF_W-1:0]     wr_data,
    input  logic                  evt_in,
    output logic                  flag_lo,
    output logic                  flag_hi,
    output logic [2*HALF_W-1:0]   count
);

    localparam int unsigned NHALF = 2;

    tmr_mode_e        mode_q;
    logic [NHALF-1:0] run_q;
    logic [HALF_W-1:0] match_q [NHALF];
    logic [NHALF-1:0] flag_q;

    logic              tick, evt_rise, wide;
    logic              src_lo, src_hi, wide_step, both_match, lo_at_max;
    logic [NHALF-1:0]  h_step, h_clr, h_match, flag_set, flag_wclr;
    logic [HALF_W-1:0] h_cnt [NHALF];
    logic              wr_ctrl, wr_reload;

    assign wr_ctrl   = wr_en && (wr_addr == REG_CTRL);
    assign wr_reload = wr_en && (wr_addr == REG_RELOAD);
    assign flag_wclr = (wr_en && (wr_addr == REG_FLAG_CLR)) ? wr_data[NHALF-1:0] : '0;

    // Control and match registers written from the software port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= MODE_PAIR;
            run_q      <= '0;
            match_q[0] <= '1;
            match_q[1] <= '1;
        end else if (wr_en) begin
            if (wr_ctrl) begin
                mode_q <= tmr_mode_e'(wr_data[1:0]);
                run_q  <= wr_data[3:2];
            end
            if (wr_addr == REG_MATCH_LO) match_q[0] <= wr_data;
            if (wr_addr == REG_MATCH_HI) match_q[1] <= wr_data;
        end
    end

    stm_prescaler #(
        .FIX_W (FIX_W),
        .PRE_W (PRE_W)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc_en   (cyc_en),
        .load     (wr_reload),
        .load_val (wr_data[PRE_W-1:0]),
        .tick     (tick)
    );

    stm_event_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt_in),
        .rise  (evt_rise)
    );

    // Choose each half's clock source and its step/clear per mode
    always_comb begin
        wide       = (mode_q == MODE_CASCADE) || (mode_q == MODE_EVENT16);
        src_lo     = (mode_q == MODE_EVENT16) ? evt_rise : tick;
        src_hi     = (mode_q == MODE_PAIR || mode_q == MODE_CASCADE) ? tick : evt_rise;
        lo_at_max  = &h_cnt[0];
        both_match = h_match[0] && h_match[1];
        wide_step  = src_lo && run_q[0];
        if (wide) begin
            h_step[0]   = wide_step;
            h_step[1]   = wide_step && lo_at_max && !both_match;
            h_clr[0]    = wide_step && both_match;
            h_clr[1]    = wide_step && both_match;
            flag_set[0] = 1'b0;
            flag_set[1] = wide_step && both_match;
        end else begin
            h_step[0]   = src_lo && run_q[0];
            h_step[1]   = src_hi && run_q[1];
            h_clr[0]    = h_step[0] && h_match[0];
            h_clr[1]    = h_step[1] && h_match[1];
            flag_set    = h_clr;
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < NHALF; gi++) begin : g_half
            stm_half #(
                .W (HALF_W)
            ) u_half (
                .clk       (clk),
                .rst_n     (rst_n),
                .step      (h_step[gi]),
                .clr       (h_clr[gi]),
                .match_val (match_q[gi]),
                .cnt       (h_cnt[gi]),
                .at_match  (h_match[gi])
            );

            // Sticky flag: a set in the same cycle beats a software clear
            always_ff @(posedge clk) begin
                if (!rst_n) flag_q[gi] <= 1'b0;
                else        flag_q[gi] <= flag_set[gi] || (flag_q[gi] && !flag_wclr[gi]);
            end
        end
    endgenerate

    assign flag_lo = flag_q[0];
    assign flag_hi = flag_q[1];
    assign count   = {h_cnt[1], h_cnt[0]};

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[0] && !flag_wclr[0]) |=> flag_q[0]); // R10
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        flag_set[1] |=> flag_q[1]); // R10
    AST_WIDE_LO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (wide && !flag_q[0]) |=> !flag_q[0]); // R8
    AST_EVENT16_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_EVENT16 && !evt_rise) |=> $stable(count)); // R7
    AST_STOPPED_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q[0] |=> $stable(h_cnt[0])); // R11

endmodule

// File: tb/sim_split_timer16.sv
// Directed bench: each scenario resets the block, programs it, and checks
// count and flags at cycles derived from the requirements.
module sim_split_timer16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_en = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        evt_in = 1'b0;
    logic        flag_lo, flag_hi;
    logic [15:0] count;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    split_timer16 u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .cyc_en  (cyc_en),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .evt_in  (evt_in),
        .flag_lo (flag_lo),
        .flag_hi (flag_hi),
        .count   (count)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0; cyc_en = 1'b1; evt_in = 1'b0;
        wait_cyc(2);
        rst_n = 1'b1;
    endtask

    // Reload written two edges before control; ticks then land at
    // j = 4*(rel+1)*k - 2 edges after setup returns (R12 register map)
    task automatic setup(input logic [1:0] mode, input logic [1:0] runs,
                         input logic [7:0] mlo, input logic [7:0] mhi, input logic [7:0] rel);
        do_reset();
        wr(3'd2, mlo);
        wr(3'd3, mhi);
        wr(3'd1, rel);
        wr(3'd0, {4'b0, runs, mode});
    endtask

    task automatic pulse(input int hi, input int lo);
        evt_in = 1'b1; wait_cyc(hi);
        evt_in = 1'b0; wait_cyc(lo);
    endtask

    task automatic t_reset;
        do_reset();
        check("R1 count", count, 16'h0000);
        check("R1 flags", {flag_hi, flag_lo}, 2'b00);
    endtask

    task automatic t_prescale;
        setup(2'd0, 2'b01, 8'hFF, 8'hFF, 8'd2);
        wait_cyc(9);  check("R2 before first tick", count, 16'h0000);
        wait_cyc(1);  check("R2 first tick", count, 16'h0001);
        wait_cyc(11); check("R2 before second tick", count, 16'h0001);
        wait_cyc(1);  check("R2 second tick, R11 high half idle", count, 16'h0002);
        cyc_en = 1'b0;
        wait_cyc(40); check("R2 cyc_en low pauses", count, 16'h0002);
        cyc_en = 1'b1;
        wr(3'd0, 8'h00);
        wait_cyc(40); check("R11 run bit cleared holds", count, 16'h0002);
    endtask

    task automatic t_restart;
        setup(2'd0, 2'b01, 8'hFF, 8'hFF, 8'd3);
        wait_cyc(10);
        wr(3'd1, 8'd0);
        check("R3 no tick yet", count, 16'h0000);
        wait_cyc(3);  check("R3 old tick suppressed", count, 16'h0000);
        wait_cyc(1);  check("R3 tick after restart", count, 16'h0001);
    endtask

    task automatic t_pair;
        setup(2'd0, 2'b11, 8'd2, 8'd5, 8'd0);
        wait_cyc(2);  check("R4 both halves step", count, 16'h0101);
        wait_cyc(8);  check("R4 low clears at match", count, 16'h0300);
        check("R4 flag_lo set only", {flag_hi, flag_lo}, 2'b01);
        wait_cyc(12); check("R4 R12 high clears at match", count, 16'h0000);
        check("R4 both flags", {flag_hi, flag_lo}, 2'b11);
        wr(3'd4, 8'h01);
        check("R10 clear low only", {flag_hi, flag_lo}, 2'b10);
    endtask

    task automatic t_mixed;
        setup(2'd1, 2'b11, 8'hFF, 8'hFF, 8'd0);
        for (int i = 0; i < 3; i++) pulse(3, 3);
        wait_cyc(5);
        check("R5 high events, low ticks", count, {8'd3, 8'd6});
    endtask

    task automatic t_cascade;
        setup(2'd2, 2'b01, 8'hFF, 8'hFF, 8'd0);
        wait_cyc(1034);
        check("R6 R11 carry into high half", count, 16'h0103);
    endtask

    task automatic t_wide_match;
        setup(2'd2, 2'b01, 8'd2, 8'd1, 8'd0);
        wait_cyc(10);
        check("R8 partial match no clear", count, 16'h0003);
        check("R8 no flags", {flag_hi, flag_lo}, 2'b00);
        setup(2'd2, 2'b01, 8'd3, 8'd0, 8'd0);
        wait_cyc(10); check("R8 reaches match", count, 16'h0003);
        wait_cyc(4);  check("R8 full match clears", count, 16'h0000);
        check("R8 only flag_hi", {flag_hi, flag_lo}, 2'b10);
    endtask

    task automatic t_event16;
        setup(2'd3, 2'b01, 8'hFF, 8'hFF, 8'd0);
        pulse(20, 3);
        check("R9 held level counts once, R7", count, 16'h0001);
        for (int i = 0; i < 4; i++) pulse(1, 2);
        wait_cyc(4);
        check("R7 R9 each edge counts", count, 16'h0005);
    endtask

    task automatic t_flag_clear;
        setup(2'd0, 2'b01, 8'd0, 8'hFF, 8'd0);
        wait_cyc(4);
        wr(3'd4, 8'h01);
        check("R10 set wins over clear", flag_lo, 1'b1);
        wr(3'd4, 8'h01);
        check("R10 clear works", flag_lo, 1'b0);
        wait_cyc(2);
        check("R10 set again", flag_lo, 1'b1);
    endtask

    initial begin
        t_reset();
        t_prescale();
        t_restart();
        t_pair();
        t_mixed();
        t_cascade();
        t_wide_match();
        t_event16();
        t_flag_clear();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule